// File: doc/BRIEF.md
# Logical Device Configuration Register Bank

This block keeps the resource settings of up to eight logical devices behind a three-strobe plug-and-play style access path. Software writes a register number through an index strobe, then reads or writes that register through data strobes. Register 0x07 picks which logical device the per-device registers refer to. Each device keeps an enable byte, a 16-bit base address, an IRQ number and a DMA channel.

Device numbering: 0 is the floppy controller, 1 and 2 are the serial ports, 3 is the parallel port and 5 is the game port. Devices 4, 6 and 7 are plain storage. When a write really changes a setting that a peripheral depends on, the block raises a one-cycle reconfigure pulse for that device. In the same cycle it shows the device's updated enable bit, base address and IRQ, so the peripheral can rebuild its decode. Every access is gated by an external enable input.

Top module: `pnp_devcfg`

## Requirements
- R1: After reset these values hold. Device 0: enable 0x01, base 0x03F0, IRQ 6, DMA 2. Device 1: enable 0x01, base 0x03F8, IRQ 4. Device 2: enable 0x01, base 0x02F8, IRQ 3. Device 3: enable 0x01, base 0x0378, IRQ 7. Every other field of every device is 0, and no reconfigure pulse is active.
- R2: An accepted index write stores `wdata` as the current register number. An accepted data write while register 0x07 is current sets the current device to `wdata[2:0]`. Reading register 0x07 returns the current device number, zero-extended to 8 bits.
- R3: The per-device registers belong to the current device only. They are 0x30 (enable byte, bit 0 = active), 0x60 (base address high byte), 0x61 (base address low byte), 0x70 (IRQ) and 0x74 (DMA). A data write stores `wdata` into the addressed field, and a read returns that field.
- R4: Any register number other than 0x07, 0x30, 0x60, 0x61, 0x70 and 0x74 reads as 0xFF. A data write to such a register changes no stored value and raises no pulse.
- R5: For devices 1, 2 and 3, a data write that changes the stored value of any of the five fields raises `recfg_pulse[dev]` in the cycle after the write edge. In that same cycle `recfg_en`, `recfg_base` and `recfg_irq` show the device's updated enable bit 0, base address and IRQ.
- R6: A data write that stores a value equal to the one already held raises no pulse.
- R7: Device 0 pulses only when its enable byte changes. Writes to its base address, IRQ or DMA store the value but raise no pulse.
- R8: Devices 4 to 7 store and return all five fields but never pulse.
- R9: While `cfg_en` is low, all three strobes are ignored, `rdata` is 0xFF, and the stored settings, register number and device number are kept.
- R10: At most one pulse bit is high in any cycle, and each pulse lasts exactly one cycle per changing write.
- R11: `rdata` carries the addressed value only while `data_rd` and `cfg_en` are both high. Otherwise it reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_en | input | 1 | Access enable for all three strobes |
| idx_wr | input | 1 | Index write strobe |
| data_wr | input | 1 | Data write strobe |
| data_rd | input | 1 | Data read strobe |
| wdata | input | 8 | Write data for index and data writes |
| rdata | output | 8 | Read data, 0xFF when not reading |
| recfg_pulse | output | NUM_DEV | One-cycle per-device reconfigure pulse |
| recfg_en | output | 1 | Enable bit 0 of the last pulsed device |
| recfg_base | output | 16 | Base address of the last pulsed device |
| recfg_irq | output | 8 | IRQ of the last pulsed device |

## Verification
The bound checker watches these rules on every cycle:
- At most one pulse is high at a time.
- A pulse only ever follows an accepted data write.
- Devices 4 to 7 never pulse.
- A floppy pulse only follows a write to the enable register.
- Writes to undefined registers stay silent.
- `rdata` is 0xFF whenever no enabled read is in progress.

Other behaviour can only be shown by the bench's directed scenarios, because it depends on stored history:
- the reset defaults;
- banking by device number;
- equal-value writes staying silent;
- the values shown alongside a pulse;
- settings kept while access is disabled.

// File: rtl/pnp_devcfg_pkg.sv
package pnp_devcfg_pkg;

  localparam logic [7:0] REG_DEVSEL  = 8'h07;
  localparam logic [7:0] REG_ENABLE  = 8'h30;
  localparam logic [7:0] REG_BASE_HI = 8'h60;
  localparam logic [7:0] REG_BASE_LO = 8'h61;
  localparam logic [7:0] REG_IRQ     = 8'h70;
  localparam logic [7:0] REG_DMA     = 8'h74;

  typedef enum logic [2:0] {
    F_NONE, F_DEVSEL, F_ENABLE, F_BASE_HI, F_BASE_LO, F_IRQ, F_DMA
  } field_e;

  typedef enum logic [1:0] {EV_NEVER, EV_ENABLE_ONLY, EV_ANY} evmode_e;

  typedef struct packed {
    logic [7:0]  en;
    logic [15:0] base;
    logic [7:0]  irq;
    logic [7:0]  dma;
  } devcfg_t;

  function automatic field_e decode_reg(input logic [7:0] r);
    case (r)
      REG_DEVSEL:  return F_DEVSEL;
      REG_ENABLE:  return F_ENABLE;
      REG_BASE_HI: return F_BASE_HI;
      REG_BASE_LO: return F_BASE_LO;
      REG_IRQ:     return F_IRQ;
      REG_DMA:     return F_DMA;
      default:     return F_NONE;
    endcase
  endfunction

  function automatic evmode_e dev_evmode(input int d);
    case (d)
      0:       return EV_ENABLE_ONLY;
      1, 2, 3: return EV_ANY;
      default: return EV_NEVER;
    endcase
  endfunction

  function automatic devcfg_t dev_default(input int d);
    devcfg_t c;
    c = '0;
    case (d)
      0: begin c.en = 8'h01; c.base = 16'h03F0; c.irq = 8'd6; c.dma = 8'd2; end
      1: begin c.en = 8'h01; c.base = 16'h03F8; c.irq = 8'd4; end
      2: begin c.en = 8'h01; c.base = 16'h02F8; c.irq = 8'd3; end
      3: begin c.en = 8'h01; c.base = 16'h0378; c.irq = 8'd7; end
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pnp_index_ctl.sv
module pnp_index_ctl
  import pnp_devcfg_pkg::*;
#(
  parameter int NUM_DEV = 8,
  localparam int DW = $clog2(NUM_DEV)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_en,
  input  logic          idx_wr,
  input  logic          data_wr,
  input  logic [7:0]    wdata,
  output logic [7:0]    reg_q,
  output logic [DW-1:0] dev_q
);

  logic [7:0]    reg_d;
  logic [DW-1:0] dev_d;
  logic          reg_ld, dev_ld;

  always_comb begin
    reg_ld = cfg_en && idx_wr;
    dev_ld = cfg_en && data_wr && (reg_q == REG_DEVSEL);
    reg_d  = wdata;
    dev_d  = wdata[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q <= '0;
      dev_q <= '0;
    end else begin
      if (reg_ld) reg_q <= reg_d;
      if (dev_ld) dev_q <= dev_d;
    end
  end

endmodule

// File: rtl/pnp_dev_bank.sv
module pnp_dev_bank
  import pnp_devcfg_pkg::*;
#(
  parameter int NUM_DEV = 8,
  localparam int DW = $clog2(NUM_DEV)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_ok,
  input  logic [DW-1:0]              wr_dev,
  input  field_e                     wr_fld,
  input  logic [7:0]                 wdata,
  output devcfg_t [NUM_DEV-1:0]      cfg_q
);

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    devcfg_t q, nxt;
    logic    ld;

    always_comb begin
      ld  = wr_ok && (wr_dev == DW'(d));
      nxt = q;
      case (wr_fld)
        F_ENABLE:  nxt.en         = wdata;
        F_BASE_HI: nxt.base[15:8] = wdata;
        F_BASE_LO: nxt.base[7:0]  = wdata;
        F_IRQ:     nxt.irq        = wdata;
        F_DMA:     nxt.dma        = wdata;
        default:   nxt            = q;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= dev_default(d);
      else if (ld) q <= nxt;
    end

    assign cfg_q[d] = q;
  end

endmodule

// File: rtl/pnp_evt_gen.sv
module pnp_evt_gen
  import pnp_devcfg_pkg::*;
#(
  parameter int NUM_DEV = 8,
  localparam int DW = $clog2(NUM_DEV)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_ok,
  input  logic [DW-1:0]      wr_dev,
  input  field_e             wr_fld,
  input  logic [7:0]         old_byte,
  input  logic [7:0]         new_byte,
  output logic [NUM_DEV-1:0] pulse_q,
  output logic [DW-1:0]      evt_dev_q
);

  logic [NUM_DEV-1:0] hit;
  logic [DW-1:0]      evt_dev_d;
  logic               changed;

  assign changed = (old_byte != new_byte);

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_hit
    localparam evmode_e MODE = dev_evmode(d);
    logic relevant;
    if (MODE == EV_ANY) begin : g_any
      assign relevant = 1'b1;
    end else if (MODE == EV_ENABLE_ONLY) begin : g_en
      assign relevant = (wr_fld == F_ENABLE);
    end else begin : g_never
      assign relevant = 1'b0;
    end
    assign hit[d] = wr_ok && (wr_dev == DW'(d)) && changed && relevant;
  end

  always_comb begin
    evt_dev_d = (|hit) ? wr_dev : evt_dev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q   <= '0;
      evt_dev_q <= '0;
    end else begin
      pulse_q   <= hit;
      evt_dev_q <= evt_dev_d;
    end
  end

endmodule

// File: rtl/pnp_devcfg.sv
module pnp_devcfg
  import pnp_devcfg_pkg::*;
#(
  parameter int NUM_DEV = 8,
  localparam int DW = $clog2(NUM_DEV)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_en,
  input  logic               idx_wr,
  input  logic               data_wr,
  input  logic               data_rd,
  input  logic [7:0]         wdata,
  output logic [7:0]         rdata,
  output logic [NUM_DEV-1:0] recfg_pulse,
  output logic               recfg_en,
  output logic [15:0]        recfg_base,
  output logic [7:0]         recfg_irq
);

  logic [1:0]           rst_sync_q;
  logic                 rst_int_n;
  logic [7:0]           idx_q;
  logic [DW-1:0]        dev_q;
  logic [DW-1:0]        evt_dev_q;
  field_e               fld;
  logic                 wr_ok;
  logic [7:0]           old_byte;
  devcfg_t [NUM_DEV-1:0] cfg_q;
  devcfg_t              cur_cfg, evt_cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pnp_index_ctl #(.NUM_DEV(NUM_DEV)) u_idx (
    .clk(clk), .rst_n(rst_int_n), .cfg_en(cfg_en), .idx_wr(idx_wr),
    .data_wr(data_wr), .wdata(wdata), .reg_q(idx_q), .dev_q(dev_q)
  );

  always_comb begin
    fld     = decode_reg(idx_q);
    wr_ok   = cfg_en && data_wr && (fld != F_NONE) && (fld != F_DEVSEL);
    cur_cfg = cfg_q[dev_q];
    evt_cfg = cfg_q[evt_dev_q];
    case (fld)
      F_ENABLE:  old_byte = cur_cfg.en;
      F_BASE_HI: old_byte = cur_cfg.base[15:8];
      F_BASE_LO: old_byte = cur_cfg.base[7:0];
      F_IRQ:     old_byte = cur_cfg.irq;
      F_DMA:     old_byte = cur_cfg.dma;
      default:   old_byte = 8'hFF;
    endcase
  end

  pnp_dev_bank #(.NUM_DEV(NUM_DEV)) u_bank (
    .clk(clk), .rst_n(rst_int_n), .wr_ok(wr_ok), .wr_dev(dev_q),
    .wr_fld(fld), .wdata(wdata), .cfg_q(cfg_q)
  );

  pnp_evt_gen #(.NUM_DEV(NUM_DEV)) u_evt (
    .clk(clk), .rst_n(rst_int_n), .wr_ok(wr_ok), .wr_dev(dev_q),
    .wr_fld(fld), .old_byte(old_byte), .new_byte(wdata),
    .pulse_q(recfg_pulse), .evt_dev_q(evt_dev_q)
  );

  always_comb begin
    rdata = 8'hFF;
    if (cfg_en && data_rd) begin
      if (fld == F_DEVSEL) rdata = 8'(dev_q);
      else                 rdata = old_byte;
    end
  end

  assign recfg_en   = evt_cfg.en[0];
  assign recfg_base = evt_cfg.base;
  assign recfg_irq  = evt_cfg.irq;

endmodule

// File: rtl/pnp_devcfg_chk.sv
module pnp_devcfg_chk #(
  parameter int NUM_DEV = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_en,
  input logic               data_wr,
  input logic               data_rd,
  input logic [7:0]         rdata,
  input logic [NUM_DEV-1:0] recfg_pulse,
  input logic [7:0]         idx_q
);

  function automatic logic is_defined(input logic [7:0] r);
    return (r == 8'h07) || (r == 8'h30) || (r == 8'h60) ||
           (r == 8'h61) || (r == 8'h70) || (r == 8'h74);
  endfunction

  // R10
  pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(recfg_pulse));

  // R5
  pulse_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (recfg_pulse != '0) |-> $past(cfg_en && data_wr));

  // R9
  disabled_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |-> (rdata == 8'hFF));

  // R11
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_rd |-> (rdata == 8'hFF));

  // R8
  quiet_devices_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (recfg_pulse >> 4) == '0);

  // R7
  floppy_enable_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recfg_pulse[0] |-> $past(idx_q == 8'h30));

  // R4
  undefined_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !is_defined(idx_q)) |=> (recfg_pulse == '0));

endmodule

bind pnp_devcfg pnp_devcfg_chk #(.NUM_DEV(NUM_DEV)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .data_wr(data_wr),
  .data_rd(data_rd), .rdata(rdata), .recfg_pulse(recfg_pulse), .idx_q(idx_q)
);

// File: tb/sim_pnp_devcfg.sv
`timescale 1ns/100ps
module sim_pnp_devcfg;

  logic        clk = 1'b0;
  logic        rst_n, cfg_en, idx_wr, data_wr, data_rd;
  logic [7:0]  wdata, rdata;
  logic [7:0]  recfg_pulse;
  logic        recfg_en;
  logic [15:0] recfg_base;
  logic [7:0]  recfg_irq;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [7:0]  cap_pulse, cap_irq;
  logic        cap_en;
  logic [15:0] cap_base;

  always #2.5 clk = ~clk;

  pnp_devcfg u0 (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .idx_wr(idx_wr),
    .data_wr(data_wr), .data_rd(data_rd), .wdata(wdata), .rdata(rdata),
    .recfg_pulse(recfg_pulse), .recfg_en(recfg_en),
    .recfg_base(recfg_base), .recfg_irq(recfg_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_idx(input logic [7:0] v);
    idx_wr = 1'b1; wdata = v;
    @(negedge clk);
    idx_wr = 1'b0;
  endtask

  task automatic do_data(input logic [7:0] v);
    data_wr = 1'b1; wdata = v;
    @(negedge clk);
    data_wr   = 1'b0;
    cap_pulse = recfg_pulse;
    cap_en    = recfg_en;
    cap_base  = recfg_base;
    cap_irq   = recfg_irq;
  endtask

  task automatic rd_now(output logic [7:0] v);
    data_rd = 1'b1;
    #1 v = rdata;
    data_rd = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] r, output logic [7:0] v);
    do_idx(r);
    rd_now(v);
  endtask

  task automatic sel_dev(input logic [7:0] d);
    do_idx(8'h07);
    do_data(d);
  endtask

  task automatic wr_reg(input logic [7:0] r, input logic [7:0] v);
    do_idx(r);
    do_data(v);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    logic [7:0] en_e [4]  = '{8'h01, 8'h01, 8'h01, 8'h01};
    logic [15:0] b_e [4]  = '{16'h03F0, 16'h03F8, 16'h02F8, 16'h0378};
    logic [7:0] irq_e [4] = '{8'd6, 8'd4, 8'd3, 8'd7};
    logic [7:0] dma_e [4] = '{8'd2, 8'd0, 8'd0, 8'd0};
    chk("R1 pulse idle", recfg_pulse, 0);
    #1 chk("R11 idle rdata", rdata, 8'hFF);
    for (int d = 0; d < 4; d++) begin
      sel_dev(8'(d));
      rd_reg(8'h30, v); chk("R1 enable", v, en_e[d]);
      rd_reg(8'h60, v); chk("R1 base hi", v, b_e[d][15:8]);
      rd_reg(8'h61, v); chk("R1 base lo", v, b_e[d][7:0]);
      rd_reg(8'h70, v); chk("R1 irq", v, irq_e[d]);
      rd_reg(8'h74, v); chk("R1 dma", v, dma_e[d]);
    end
    sel_dev(8'd5);
    rd_reg(8'h30, v); chk("R1 game enable", v, 0);
    rd_reg(8'h60, v); chk("R1 game base hi", v, 0);
    rd_reg(8'h70, v); chk("R1 game irq", v, 0);
  endtask

  task automatic t_select;
    logic [7:0] v;
    sel_dev(8'h0B);
    rd_reg(8'h07, v); chk("R2 device low bits", v, 8'h03);
    rd_reg(8'h70, v); chk("R2 selected device irq", v, 8'd7);
  endtask

  task automatic t_serial;
    logic [7:0] v;
    sel_dev(8'd1);
    wr_reg(8'h70, 8'd5);
    chk("R5 pulse dev1", cap_pulse, 8'h02);
    chk("R5 shown irq", cap_irq, 8'd5);
    chk("R5 shown en", cap_en, 1);
    chk("R5 shown base", cap_base, 16'h03F8);
    @(negedge clk);
    chk("R10 pulse one cycle", recfg_pulse, 0);
    wr_reg(8'h61, 8'hF8);
    chk("R6 same value silent", cap_pulse, 0);
    wr_reg(8'h61, 8'hE8);
    chk("R5 base change pulse", cap_pulse, 8'h02);
    chk("R5 shown new base", cap_base, 16'h03E8);
    rd_reg(8'h61, v); chk("R3 readback base lo", v, 8'hE8);
    sel_dev(8'd2);
    rd_reg(8'h70, v); chk("R3 banking dev2 irq", v, 8'd3);
    sel_dev(8'd3);
    wr_reg(8'h74, 8'd1);
    chk("R5 dma change pulse dev3", cap_pulse, 8'h08);
    chk("R5 shown base dev3", cap_base, 16'h0378);
  endtask

  task automatic t_floppy;
    logic [7:0] v;
    sel_dev(8'd0);
    wr_reg(8'h60, 8'h01);
    chk("R7 base write silent", cap_pulse, 0);
    rd_reg(8'h60, v); chk("R7 base stored", v, 8'h01);
    wr_reg(8'h74, 8'd3);
    chk("R7 dma write silent", cap_pulse, 0);
    wr_reg(8'h70, 8'd9);
    chk("R7 irq write silent", cap_pulse, 0);
    wr_reg(8'h30, 8'h00);
    chk("R7 enable change pulse", cap_pulse, 8'h01);
    chk("R7 shown en", cap_en, 0);
    wr_reg(8'h30, 8'h00);
    chk("R6 floppy same enable", cap_pulse, 0);
  endtask

  task automatic t_undef;
    logic [7:0] v;
    sel_dev(8'd3);
    wr_reg(8'h40, 8'h99);
    chk("R4 undefined write silent", cap_pulse, 0);
    rd_now(v); chk("R4 undefined reads FF", v, 8'hFF);
    rd_reg(8'h30, v); chk("R4 enable untouched", v, 8'h01);
    rd_reg(8'h70, v); chk("R4 irq untouched", v, 8'd7);
  endtask

  task automatic t_quiet;
    logic [7:0] v;
    sel_dev(8'd5);
    wr_reg(8'h70, 8'd9);
    chk("R8 game silent", cap_pulse, 0);
    rd_reg(8'h70, v); chk("R8 game stores", v, 8'd9);
    sel_dev(8'd7);
    wr_reg(8'h30, 8'h01);
    chk("R8 dev7 silent", cap_pulse, 0);
    rd_reg(8'h30, v); chk("R8 dev7 stores", v, 8'h01);
  endtask

  task automatic t_disabled;
    logic [7:0] v;
    sel_dev(8'd1);
    do_idx(8'h70);
    cfg_en = 1'b0;
    do_data(8'h0F);
    chk("R9 write ignored", cap_pulse, 0);
    rd_now(v); chk("R9 rdata FF", v, 8'hFF);
    do_idx(8'h07);
    cfg_en = 1'b1;
    rd_now(v); chk("R9 settings kept", v, 8'd5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_en = 1'b1; idx_wr = 1'b0; data_wr = 1'b0;
    data_rd = 1'b0; wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_select();
    t_serial();
    t_floppy();
    t_undef();
    t_quiet();
    t_disabled();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule